// File: doc/BRIEF.md
# IR Transmit Carrier Modulator

This block turns a queue of pulse-width entries into the waveform that drives an infrared emitter. Software, or a neighbouring block, writes entries into an eight-deep queue. Each entry holds a 16-bit width field and a level bit that marks it as a mark or a space. The block plays the entries one after another with no gap between them. It counts each entry's duration in transmit ticks, and a programmable 16-bit divider sets the length of one tick in reference clocks.

While an entry plays, the block can gate a carrier onto the output. One carrier period is always 16 ticks long. A 4-bit duty field sets how many of those 16 ticks the carrier is high. A polarity control chooses whether marks or spaces carry the burst, and a separate control inverts the final pin. When modulation is off, the entry that would carry the burst drives the pin as a plain steady level.

Status outputs report whether an entry is playing and whether the queue needs refilling. The refill threshold is selectable. A one-cycle interrupt pulse marks each new refill request.

Top module: `ir_tx_modulator`

## Requirements
- R1: One transmit tick lasts `divider`+1 clocks. An entry with width field w stays loaded for ((w<<2)|3) ticks, which is ((w<<2)|3)*(`divider`+1) clocks in all.
- R2: When `tx_enable` is set, no entry is playing and the queue holds an entry, `busy` rises at the next clock. When an entry ends and another is queued, the next one starts with no idle cycle between them.
- R3: With modulation on, the carrier phase restarts at 0 when an entry loads and advances once per tick, modulo 16. The carrier is high in phases 0 to `duty`, so it is high for `duty`+1 ticks out of every 16.
- R4: A burst-carrying entry is one whose level bit (1 = mark, 0 = space) is not equal to `burst_on_space`. Only burst-carrying entries drive the pin active.
- R5: With `mod_enable` clear, a burst-carrying entry holds the pin active for its whole duration, and any other entry holds the pin inactive.
- R6: `invert_out` inverts `ir_out` at all times. This includes idle, when the un-inverted pin is 0.
- R7: The queue holds at most 8 entries and plays them in write order. A write to a full queue is dropped.
- R8: While `fifo_enable` is clear, the queue is emptied, writes are dropped and no entry is loaded.
- R9: `svc_req` is high when the queue holds 4 or fewer entries if `wm_empty` is 0, and only when the queue is empty if `wm_empty` is 1.
- R10: `irq` is a one-cycle pulse. It is registered and appears one clock after the clock edge at which `svc_req` AND `tx_enable` AND `fifo_enable` changes from 0 to 1.
- R11: `busy` is high exactly while an entry plays. After reset, and when the last queued entry ends, the block is idle. Clearing `tx_enable` abandons the current entry and leaves the block idle at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry into the queue |
| wr_width | input | 16 | Width field of the written entry |
| wr_level | input | 1 | Level bit of the written entry (1 = mark) |
| fifo_enable | input | 1 | Queue enable; while clear, the queue is flushed |
| tx_enable | input | 1 | Transmitter enable |
| mod_enable | input | 1 | Gate the carrier onto burst-carrying entries |
| divider | input | 16 | Tick length minus one, in clocks |
| duty | input | 4 | Carrier high ticks minus one, out of 16 |
| burst_on_space | input | 1 | Spaces carry the burst instead of marks |
| invert_out | input | 1 | Invert the output pin |
| wm_empty | input | 1 | Request service only when empty (else at half empty) |
| ir_out | output | 1 | Infrared output pin |
| busy | output | 1 | An entry is playing |
| svc_req | output | 1 | Queue wants refilling |
| irq | output | 1 | One-cycle pulse on a new gated service request |

## Verification
Two cases are hard to reach from the ports: a write that arrives while the queue is full, and a handover from one entry to the next with no idle cycle between them. To reach both, the bench fills the queue with the transmitter disabled and writes past the capacity. It then enables the transmitter with a zero divider and minimum widths. Each entry then lasts three clocks, so the count of busy cycles shows both that the extra writes were dropped and that the entries ran without gaps. A behavioural model built from queues compares every output on every clock. It checks that the carrier phase restarts at each load and that the interrupt pulses on the first drain below the threshold.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  parameter int unsigned PW_W = 16;

  typedef struct packed {
    logic            level;
    logic [PW_W-1:0] width;
  } pulse_t;
endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo
  import ir_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  pulse_t           push_data,
  input  logic             pop,
  output pulse_t           head,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pulse_t           mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             full, empty, do_push, do_pop;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      count_d = count_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

  // R7: occupancy never exceeds the queue depth
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R7: a write into a full queue with no read leaves it full and unchanged
  assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count_q == CNT_W'(DEPTH)) && $stable(wr_ptr_q));

  // R8: a flush leaves the queue empty
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));
endmodule

// File: rtl/ir_tx_tick_gen.sv
module ir_tx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q >= divider);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ir_tx_player.sv
module ir_tx_player
  import ir_tx_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               avail,
  input  pulse_t             head,
  input  logic               tick,
  output logic               pop,
  output logic               busy,
  output logic               level,
  output logic [PHASE_W-1:0] phase
);
  localparam int REM_W = PW_W + 2;

  logic               busy_q, busy_d;
  logic               level_q, level_d;
  logic [REM_W-1:0]   rem_q, rem_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               last;

  assign last = busy_q && tick && (rem_q == REM_W'(1));
  assign pop  = enable && avail && (!busy_q || last);

  always_comb begin
    busy_d  = enable && (busy_q ? (!last || avail) : avail);
    rem_d   = rem_q;
    phase_d = phase_q;
    level_d = level_q;
    if (pop) begin
      rem_d   = {head.width, 2'b11};
      phase_d = '0;
      level_d = head.level;
    end else if (busy_q && tick) begin
      rem_d   = rem_q - 1'b1;
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      level_q <= 1'b0;
      rem_q   <= '0;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_d;
      level_q <= level_d;
      rem_q   <= rem_d;
      phase_q <= phase_d;
    end
  end

  assign busy  = busy_q;
  assign level = level_q;
  assign phase = phase_q;

  // R1: the remaining duration only moves on a tick
  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && enable && !tick) |=> $stable(rem_q) && busy_q);

  // R11: the last tick of an entry with nothing queued returns to idle
  assert_idle_when_dry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !avail) |=> !busy_q);

  // R11: a disabled transmitter is idle at the next clock
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_q);
endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
  import ir_tx_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DIV_W   = 16,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PW_W-1:0]    wr_width,
  input  logic               wr_level,
  input  logic               fifo_enable,
  input  logic               tx_enable,
  input  logic               mod_enable,
  input  logic [DIV_W-1:0]   divider,
  input  logic [PHASE_W-1:0] duty,
  input  logic               burst_on_space,
  input  logic               invert_out,
  input  logic               wm_empty,
  output logic               ir_out,
  output logic               busy,
  output logic               svc_req,
  output logic               irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  pulse_t             wr_data, head;
  logic [CNT_W-1:0]   count;
  logic               pop, tick, play_level;
  logic [PHASE_W-1:0] phase;
  logic               carrier_hi, burst_entry, raw_pin;
  logic               req_gated, req_gated_q, irq_q;

  assign wr_data = '{level: wr_level, width: wr_width};

  ir_tx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!fifo_enable),
    .push      (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  ir_tx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .divider (divider),
    .tick    (tick)
  );

  ir_tx_player #(.PHASE_W(PHASE_W)) u_player (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (tx_enable),
    .avail  (fifo_enable && (count != '0)),
    .head   (head),
    .tick   (tick),
    .pop    (pop),
    .busy   (busy),
    .level  (play_level),
    .phase  (phase)
  );

  // carrier shaping and pin polarity
  assign carrier_hi  = (phase <= duty);
  assign burst_entry = play_level ^ burst_on_space;
  assign raw_pin     = busy && burst_entry && (!mod_enable || carrier_hi);
  assign ir_out      = raw_pin ^ invert_out;

  // service request and its interrupt pulse
  assign svc_req   = wm_empty ? (count == '0) : (count <= CNT_W'(HALF));
  assign req_gated = svc_req && tx_enable && fifo_enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_gated_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      req_gated_q <= req_gated;
      irq_q       <= req_gated && !req_gated_q;
    end
  end

  assign irq = irq_q;

  // R6: an idle transmitter drives only the inversion level
  assert_idle_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ir_out == invert_out));

  // R10: the interrupt never lasts two cycles
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: without modulation the pin holds steady inside an entry
  assert_plain_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mod_enable && !pop) ##1 (busy && !mod_enable && !pop &&
      $stable(burst_on_space) && $stable(invert_out)) |-> $stable(ir_out));
endmodule

// File: tb/tb_ir_tx_modulator.sv
module tb_ir_tx_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk, rst_n;
  logic        wr_en, wr_level;
  logic [15:0] wr_width;
  logic        fifo_enable, tx_enable, mod_enable;
  logic [15:0] divider;
  logic [3:0]  duty;
  logic        burst_on_space, invert_out, wm_empty;
  logic        ir_out, busy, svc_req, irq;

  ir_tx_modulator dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_width(wr_width), .wr_level(wr_level),
    .fifo_enable(fifo_enable), .tx_enable(tx_enable), .mod_enable(mod_enable),
    .divider(divider), .duty(duty), .burst_on_space(burst_on_space),
    .invert_out(invert_out), .wm_empty(wm_empty),
    .ir_out(ir_out), .busy(busy), .svc_req(svc_req), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string tag    = "R11";

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned q_width[$];
  bit          q_level[$];
  bit          m_busy, m_level, m_irq, m_gd;
  int unsigned m_rem, m_phase, m_tc;

  function automatic bit m_svc();
    return wm_empty ? (q_width.size() == 0) : (q_width.size() <= DEPTH / 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_width.delete(); q_level.delete();
      m_busy = 0; m_level = 0; m_irq = 0; m_gd = 0;
      m_rem = 0; m_phase = 0; m_tc = 0;
    end else begin
      bit gated, avail, tck, last, pop, nb;
      int old_size;
      gated = m_svc() && tx_enable && fifo_enable;
      m_irq = gated && !m_gd;
      m_gd  = gated;
      avail = fifo_enable && (q_width.size() > 0);
      tck   = m_busy && (m_tc >= divider);
      last  = tck && (m_rem == 1);
      pop   = tx_enable && avail && (!m_busy || last);
      nb    = tx_enable && (m_busy ? (!last || avail) : avail);
      m_tc  = (!m_busy || tck) ? 0 : m_tc + 1;
      if (pop) begin
        m_rem   = (q_width[0] << 2) | 3;
        m_phase = 0;
        m_level = q_level[0];
      end else if (m_busy && tck) begin
        m_rem   = m_rem - 1;
        m_phase = (m_phase + 1) % 16;
      end
      m_busy   = nb;
      old_size = q_width.size();
      if (!fifo_enable) begin
        q_width.delete(); q_level.delete();
      end else begin
        if (pop) begin
          void'(q_width.pop_front()); void'(q_level.pop_front());
        end
        if (wr_en && old_size < DEPTH) begin
          q_width.push_back(wr_width); q_level.push_back(wr_level);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_pin;
      exp_pin = (m_busy && (m_level ^ burst_on_space) &&
                 (!mod_enable || (m_phase <= duty))) ^ invert_out;
      check(ir_out === exp_pin, tag, "ir_out vs model", int'(ir_out), int'(exp_pin));
      check(busy === m_busy, "R11", "busy vs model", int'(busy), int'(m_busy));
      check(svc_req === m_svc(), "R9", "svc_req vs model", int'(svc_req), int'(m_svc()));
      check(irq === m_irq, "R10", "irq vs model", int'(irq), int'(m_irq));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input bit lv, input int unsigned w);
    wr_en = 1'b1; wr_level = lv; wr_width = 16'(w);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int cycles, input string sig, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sig == "busy" && busy) n++;
      if (sig == "pin" && ir_out) n++;
      if (sig == "irq" && irq) n++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 0; wr_level = 0; wr_width = 0;
    fifo_enable = 0; tx_enable = 0; mod_enable = 0; divider = 0; duty = 0;
    burst_on_space = 0; invert_out = 0; wm_empty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 0 && ir_out == 0 && irq == 0, "R11", "idle after reset", int'(busy), 0);
    check(svc_req == 1, "R9", "request with empty queue", int'(svc_req), 1);

    // R1: tick length and entry duration, R2 load on next clock
    tag = "R1"; fifo_enable = 1; tx_enable = 1; divider = 2;
    put(1, 1);
    check(busy == 0, "R2", "not yet loaded after write", int'(busy), 0);
    @(negedge clk);
    check(busy == 1, "R2", "loaded one clock later", int'(busy), 1);
    count_high(40, "busy", n);
    check(n == 20, "R1", "busy clocks of w=1 div=2 (after first)", n, 20);

    // R3: carrier duty and phase restart
    tag = "R3"; mod_enable = 1; duty = 3; divider = 1;
    put(1, 10);
    count_high(100, "pin", n);
    check(n == 24, "R3", "carrier high clocks of 43-tick entry", n, 24);
    duty = 15; put(1, 1); put(1, 2);
    repeat (40) @(negedge clk);

    // R4: polarity swap, R5 plain levels
    tag = "R4"; mod_enable = 0; burst_on_space = 1; divider = 0;
    put(0, 2);
    check(ir_out == 0, "R4", "space not yet loaded", int'(ir_out), 0);
    @(negedge clk);
    check(ir_out == 1, "R4", "space carries burst with swap", int'(ir_out), 1);
    put(1, 2); put(0, 0);
    tag = "R5";
    repeat (30) @(negedge clk);
    burst_on_space = 0;

    // R6: inversion at idle
    tag = "R6"; invert_out = 1;
    @(negedge clk);
    check(ir_out == 1, "R6", "inverted idle pin", int'(ir_out), 1);
    put(1, 0); repeat (6) @(negedge clk);
    invert_out = 0;

    // R7: full queue drops writes, R2 back-to-back
    tag = "R7"; tx_enable = 0;
    for (int i = 0; i < 10; i++) put(i[0], 0);
    check(svc_req == 0, "R7", "no request when full", int'(svc_req), 0);
    tx_enable = 1;
    count_high(40, "busy", n);
    check(n == 24, "R7", "8 entries of 3 clocks played", n, 24);
    check(n == 24, "R2", "no gap between queued entries", n, 24);

    // R8: disabled queue flushes and drops
    tag = "R8"; tx_enable = 0; wm_empty = 1;
    put(1, 5); put(1, 5); put(1, 5);
    check(svc_req == 0, "R9", "empty watermark with 3 entries", int'(svc_req), 0);
    fifo_enable = 0; put(1, 5); fifo_enable = 1;
    @(negedge clk);
    check(svc_req == 1, "R8", "queue empty after disable", int'(svc_req), 1);
    tx_enable = 1;
    count_high(5, "busy", n);
    check(n == 0, "R8", "nothing to play after flush", n, 0);

    // R9: half-empty threshold, R10 single interrupt
    tag = "R9"; tx_enable = 0; wm_empty = 0;
    for (int i = 0; i < 4; i++) put(1, 0);
    check(svc_req == 1, "R9", "request at 4 entries", int'(svc_req), 1);
    put(1, 0);
    check(svc_req == 0, "R9", "no request at 5 entries", int'(svc_req), 0);
    tag = "R10"; tx_enable = 1;
    count_high(30, "irq", n);
    check(n == 1, "R10", "one pulse while draining", n, 1);

    // R11: abort
    tag = "R11"; put(1, 100);
    repeat (10) @(negedge clk);
    check(busy == 1, "R11", "long entry playing", int'(busy), 1);
    tx_enable = 0;
    @(negedge clk);
    check(busy == 0, "R11", "abort on disable", int'(busy), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule